// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Logic

This block generates the interrupt flags that let two agents sharing a two-port memory signal each other. Each port presents an active-low chip select, an active-low write strobe, an active-low output enable and a word address. The two highest addresses of the memory are reserved as mailboxes. The very top word carries messages toward the right port. The word just below it carries messages toward the left port.

When one side writes the mailbox that faces the other side, the other side's interrupt goes active (low). The receiving side clears its interrupt by reading that same mailbox. The data words are held by the memory next to this block. This block sees only the access strobes and addresses, and keeps one flag register per port.

All pins are sampled on the rising clock edge, and a flag change shows on its interrupt output one clock later. Reset is synchronous and active high.

Top module: `mbx_irq_logic`

## Requirements
- R1: While `rst` is high at a rising edge, both flags are cleared, so after that edge `l_irq_n` and `r_irq_n` are both 1 (inactive), even if they were active before.
- R2: A write access by the left port means `l_cs_n`=0 and `l_wr_n`=0. If a left write access begins at address all-ones (0xFFF with the default 12-bit address), `r_irq_n` is 0 after that edge.
- R3: If a right write access begins at address all-ones minus one (0xFFE), `l_irq_n` is 0 after that edge.
- R4: A read access means `cs_n`=0, `wr_n`=1 and `oe_n`=0. A right read access of 0xFFF drives `r_irq_n` to 1 after that edge. A left read access of 0xFFE drives `l_irq_n` to 1 after that edge.
- R5: An access with `cs_n`=0 and `wr_n`=1 but `oe_n`=1 is not a read, and it leaves the flags unchanged.
- R6: A write access sets a flag only in the first cycle in which both `cs_n` and `wr_n` are low, that is, when the later of the two becomes active. The address must equal the mailbox in that cycle. Holding the write for more cycles does not set the flag again, and changing the address to a mailbox during a held write does not set it.
- R7: If a set and a clear of the same flag occur in one cycle, the flag ends up set.
- R8: Other accesses leave both flags unchanged. These are: any access to other addresses, a port writing the mailbox addressed to itself, and a port reading the mailbox addressed to the other side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| l_cs_n | input | 1 | Left port chip select, active low |
| l_wr_n | input | 1 | Left port write strobe, active low |
| l_oe_n | input | 1 | Left port output enable, active low |
| l_addr | input | ADDR_W | Left port word address |
| r_cs_n | input | 1 | Right port chip select, active low |
| r_wr_n | input | 1 | Right port write strobe, active low |
| r_oe_n | input | 1 | Right port output enable, active low |
| r_addr | input | ADDR_W | Right port word address |
| l_irq_n | output | 1 | Interrupt toward the left port, active low |
| r_irq_n | output | 1 | Interrupt toward the right port, active low |

## Verification
Every effect of this block, whether a set, a clear, the set-wins case, or reset, shows on the interrupt pins exactly one rising edge after the cycle in which its access is presented. Nothing is delayed further. The driver applies each cycle's pins at the falling edge and queues the interrupt levels that must follow. The monitor compares one queued item shortly after each rising edge, so every check lands on the single cycle in which a result is due. Held writes, late strobes and address changes mid-access are driven over several consecutive cycles. Each intermediate cycle is compared, not only the final one.

// File: rtl/mbx_irq_pkg.sv
package mbx_irq_pkg;

    // Port indices; mailbox p is the one that interrupts port p.
    typedef enum logic {
        PORT_LEFT  = 1'b0,
        PORT_RIGHT = 1'b1
    } port_e;

    localparam int unsigned NPORTS = 2;

    // Decoded access qualifiers for one port, active high.
    typedef struct packed {
        logic wr_act;
        logic rd_act;
    } port_ctl_t;

    function automatic port_ctl_t decode_pins(input logic cs_n,
                                              input logic wr_n,
                                              input logic oe_n);
        port_ctl_t c;
        c.wr_act = !cs_n && !wr_n;
        c.rd_act = !cs_n &&  wr_n && !oe_n;
        return c;
    endfunction

    // Distance of a port's mailbox below the top address.
    function automatic int unsigned mbx_offset(input int unsigned port);
        return (port == int'(PORT_RIGHT)) ? 0 : 1;
    endfunction

endpackage

// File: rtl/mbx_port_decode.sv
module mbx_port_decode
    import mbx_irq_pkg::*;
#(
    parameter int unsigned ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  port_ctl_t         ctl,
    input  logic [ADDR_W-1:0] addr,
    output logic [NPORTS-1:0] wr_evt,
    output logic [NPORTS-1:0] rd_evt
);
    localparam logic [ADDR_W-1:0] TOP_ADDR = {ADDR_W{1'b1}};

    logic wr_act_q;
    logic wr_start;

    // Write begins when the later of select and strobe goes active.
    always_ff @(posedge clk) begin
        if (rst) wr_act_q <= 1'b0;
        else     wr_act_q <= ctl.wr_act;
    end

    assign wr_start = ctl.wr_act && !wr_act_q;

    for (genvar m = 0; m < NPORTS; m++) begin : g_mbx
        localparam logic [ADDR_W-1:0] MBX_ADDR =
            TOP_ADDR - ADDR_W'(mbx_offset(m));
        logic hit;
        assign hit       = (addr == MBX_ADDR);
        assign wr_evt[m] = wr_start   && hit;
        assign rd_evt[m] = ctl.rd_act && hit;
    end

endmodule

// File: rtl/mbx_flag.sv
module mbx_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic irq_n
);
    logic pending;

    // Set has priority over clear.
    always_ff @(posedge clk) begin
        if (rst)      pending <= 1'b0;
        else if (set) pending <= 1'b1;
        else if (clr) pending <= 1'b0;
    end

    assign irq_n = !pending;

endmodule

// File: rtl/mbx_irq_logic.sv
module mbx_irq_logic
    import mbx_irq_pkg::*;
#(
    parameter int unsigned ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              l_cs_n,
    input  logic              l_wr_n,
    input  logic              l_oe_n,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic              r_cs_n,
    input  logic              r_wr_n,
    input  logic              r_oe_n,
    input  logic [ADDR_W-1:0] r_addr,
    output logic              l_irq_n,
    output logic              r_irq_n
);
    port_ctl_t         ctl    [NPORTS];
    logic [ADDR_W-1:0] addr_a [NPORTS];
    logic [NPORTS-1:0] wr_evt [NPORTS];
    logic [NPORTS-1:0] rd_evt [NPORTS];
    logic              irq_a  [NPORTS];

    assign ctl[PORT_LEFT]     = decode_pins(l_cs_n, l_wr_n, l_oe_n);
    assign ctl[PORT_RIGHT]    = decode_pins(r_cs_n, r_wr_n, r_oe_n);
    assign addr_a[PORT_LEFT]  = l_addr;
    assign addr_a[PORT_RIGHT] = r_addr;

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        mbx_port_decode #(.ADDR_W(ADDR_W)) u_dec (
            .clk    (clk),
            .rst    (rst),
            .ctl    (ctl[p]),
            .addr   (addr_a[p]),
            .wr_evt (wr_evt[p]),
            .rd_evt (rd_evt[p])
        );

        // Flag of port p: set by the other port writing mailbox p,
        // cleared by port p reading mailbox p.
        mbx_flag u_flag (
            .clk   (clk),
            .rst   (rst),
            .set   (wr_evt[NPORTS-1-p][p]),
            .clr   (rd_evt[p][p]),
            .irq_n (irq_a[p])
        );
    end

    assign l_irq_n = irq_a[PORT_LEFT];
    assign r_irq_n = irq_a[PORT_RIGHT];

endmodule

// File: rtl/mbx_irq_logic_chk.sv
module mbx_irq_logic_chk #(
    parameter int unsigned ADDR_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              l_cs_n,
    input logic              l_wr_n,
    input logic              l_oe_n,
    input logic [ADDR_W-1:0] l_addr,
    input logic              r_cs_n,
    input logic              r_wr_n,
    input logic              r_oe_n,
    input logic [ADDR_W-1:0] r_addr,
    input logic              l_irq_n,
    input logic              r_irq_n
);
    localparam logic [ADDR_W-1:0] A_TO_R = {ADDR_W{1'b1}};
    localparam logic [ADDR_W-1:0] A_TO_L = {ADDR_W{1'b1}} - ADDR_W'(1);

    logic lw, rw, lw_q, rw_q, lrd, rrd;
    logic set_r, set_l, clr_r, clr_l;

    assign lw  = !l_cs_n && !l_wr_n;
    assign rw  = !r_cs_n && !r_wr_n;
    assign lrd = !l_cs_n && l_wr_n && !l_oe_n;
    assign rrd = !r_cs_n && r_wr_n && !r_oe_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            lw_q <= 1'b0;
            rw_q <= 1'b0;
        end else begin
            lw_q <= lw;
            rw_q <= rw;
        end
    end

    assign set_r = lw && !lw_q && (l_addr == A_TO_R);
    assign set_l = rw && !rw_q && (r_addr == A_TO_L);
    assign clr_r = rrd && (r_addr == A_TO_R);
    assign clr_l = lrd && (l_addr == A_TO_L);

    // R2
    set_right_chk: assert property (@(posedge clk) disable iff (rst)
        set_r |=> !r_irq_n);
    // R3
    set_left_chk: assert property (@(posedge clk) disable iff (rst)
        set_l |=> !l_irq_n);
    // R4
    clr_right_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_r && !set_r) |=> r_irq_n);
    // R4
    clr_left_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_l && !set_l) |=> l_irq_n);
    // R7
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (set_r && clr_r) |=> !r_irq_n);
    // R8
    hold_right_chk: assert property (@(posedge clk) disable iff (rst)
        (!set_r && !clr_r) |=> $stable(r_irq_n));
    // R8
    hold_left_chk: assert property (@(posedge clk) disable iff (rst)
        (!set_l && !clr_l) |=> $stable(l_irq_n));

endmodule

bind mbx_irq_logic mbx_irq_logic_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .l_cs_n  (l_cs_n),
    .l_wr_n  (l_wr_n),
    .l_oe_n  (l_oe_n),
    .l_addr  (l_addr),
    .r_cs_n  (r_cs_n),
    .r_wr_n  (r_wr_n),
    .r_oe_n  (r_oe_n),
    .r_addr  (r_addr),
    .l_irq_n (l_irq_n),
    .r_irq_n (r_irq_n)
);

// File: tb/mbx_irq_logic_test.sv
module mbx_irq_logic_test;
    localparam int unsigned AW = 12;
    localparam logic [AW-1:0] FFF = 12'hFFF;
    localparam logic [AW-1:0] FFE = 12'hFFE;
    localparam logic [AW-1:0] FFD = 12'hFFD;
    localparam logic [AW-1:0] Z00 = 12'h000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic l_cs_n = 1'b1, l_wr_n = 1'b1, l_oe_n = 1'b1;
    logic r_cs_n = 1'b1, r_wr_n = 1'b1, r_oe_n = 1'b1;
    logic [AW-1:0] l_addr = '0, r_addr = '0;
    logic l_irq_n, r_irq_n;

    typedef struct {
        logic  l;
        logic  r;
        string tag;
    } exp_t;

    exp_t q[$];
    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    always #2 clk = !clk;

    mbx_irq_logic #(.ADDR_W(AW)) uut (
        .clk(clk), .rst(rst),
        .l_cs_n(l_cs_n), .l_wr_n(l_wr_n), .l_oe_n(l_oe_n), .l_addr(l_addr),
        .r_cs_n(r_cs_n), .r_wr_n(r_wr_n), .r_oe_n(r_oe_n), .r_addr(r_addr),
        .l_irq_n(l_irq_n), .r_irq_n(r_irq_n)
    );

    // Driver: one cycle of pins per call; queue the levels due after the edge.
    task automatic step(input logic rs,
                        input logic lc, input logic lw, input logic lo,
                        input logic [AW-1:0] la,
                        input logic rc, input logic rw, input logic ro,
                        input logic [AW-1:0] ra,
                        input logic el, input logic er, input string tag);
        exp_t e;
        @(negedge clk);
        rst = rs;
        l_cs_n = lc; l_wr_n = lw; l_oe_n = lo; l_addr = la;
        r_cs_n = rc; r_wr_n = rw; r_oe_n = ro; r_addr = ra;
        e.l = el; e.r = er; e.tag = tag;
        q.push_back(e);
    endtask

    // Monitor: compare one item just after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                compared++;
                if (l_irq_n !== e.l || r_irq_n !== e.r) begin
                    mismatched++;
                    $display("FAIL %s: l_irq_n=%b r_irq_n=%b expected %b %b",
                             e.tag, l_irq_n, r_irq_n, e.l, e.r);
                end
            end
        end
    end

    initial begin
        // R1 reset state
        step(1, 1,1,1,Z00, 1,1,1,Z00, 1,1, "R1 reset");
        step(1, 1,1,1,Z00, 1,1,1,Z00, 1,1, "R1 reset");
        step(0, 1,1,1,Z00, 1,1,1,Z00, 1,1, "R1 idle after reset");
        // R2 left write of FFF
        step(0, 0,0,1,FFF, 1,1,1,Z00, 1,0, "R2 left write FFF");
        step(0, 1,1,1,Z00, 1,1,1,Z00, 1,0, "R2 flag held");
        // R5 read strobes without output enable
        step(0, 1,1,1,Z00, 0,1,1,FFF, 1,0, "R5 no oe no clear");
        // R8 left reads the right-bound mailbox
        step(0, 0,1,0,FFF, 1,1,1,Z00, 1,0, "R8 wrong side read");
        // R4 right read clears
        step(0, 1,1,1,Z00, 0,1,0,FFF, 1,1, "R4 right read FFF");
        // R3 right write of FFE, held
        step(0, 1,1,1,Z00, 0,0,1,FFE, 0,1, "R3 right write FFE");
        step(0, 1,1,1,Z00, 0,0,1,FFE, 0,1, "R6 held write");
        // R4 / R6 clear during held write stays cleared
        step(0, 0,1,0,FFE, 0,0,1,FFE, 1,1, "R4 left read FFE");
        step(0, 1,1,1,Z00, 0,0,1,FFE, 1,1, "R6 held write no reset");
        step(0, 1,1,1,Z00, 1,1,1,Z00, 1,1, "R6 idle");
        // R6 strobe goes active after select
        step(0, 1,1,1,Z00, 0,1,1,FFE, 1,1, "R6 select only");
        step(0, 1,1,1,Z00, 0,0,1,FFE, 0,1, "R6 late strobe sets");
        step(0, 1,1,1,Z00, 1,1,1,Z00, 0,1, "R6 idle");
        // R8 ignored accesses
        step(0, 0,0,1,FFE, 1,1,1,Z00, 0,1, "R8 left writes own mailbox");
        step(0, 1,1,1,Z00, 1,1,1,Z00, 0,1, "R8 idle");
        step(0, 0,0,1,FFD, 0,0,1,FFD, 0,1, "R8 other address write");
        step(0, 0,1,0,FFD, 0,1,0,FFD, 0,1, "R8 other address read");
        step(0, 1,1,1,Z00, 0,0,1,FFF, 0,1, "R8 right writes own mailbox");
        step(0, 1,1,1,Z00, 1,1,1,Z00, 0,1, "R8 idle");
        // R7 set and clear together
        step(0, 0,0,1,FFF, 0,1,0,FFF, 0,0, "R7 set wins");
        step(0, 1,1,1,Z00, 0,1,0,FFF, 0,1, "R4 right read clears");
        step(0, 0,1,0,FFE, 1,1,1,Z00, 1,1, "R4 left read clears");
        // R6 address moves onto the mailbox during a held write
        step(0, 0,0,1,Z00, 1,1,1,Z00, 1,1, "R6 write starts at 000");
        step(0, 0,0,1,FFF, 1,1,1,Z00, 1,1, "R6 address change no set");
        step(0, 1,1,1,Z00, 1,1,1,Z00, 1,1, "R6 idle");
        // R1 reset clears active flags
        step(0, 0,0,1,FFF, 0,0,1,FFE, 0,0, "R2 R3 both set");
        step(1, 1,1,1,Z00, 1,1,1,Z00, 1,1, "R1 reset clears");
        step(0, 1,1,1,Z00, 1,1,1,Z00, 1,1, "R1 after reset");
        repeat (3) @(posedge clk);
        #2;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: run hung, actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule